// File: doc/BRIEF.md
# Rounding Narrowing Saturating Interleave Unit

This datapath turns two vectors of signed wide elements into one vector of unsigned elements that are half as wide. Each wide element is shifted right arithmetically by an immediate amount. A rounding constant of half the shift step is added before the shift. The shifted value is then clamped to the unsigned range of the narrow element. The narrow results from the two sources are interleaved, so that wide element e of source 0 and wide element e of source 1 become adjacent narrow elements of the destination.

Two size classes exist: 16-bit signed to 8-bit unsigned, and 32-bit signed to 16-bit unsigned. A mode input selects the class, and it is sampled together with the valid strobe. The vector length is a parameter that must be a multiple of 64 bits. When a vector is presented with `in_valid_i`, the result and `out_valid_o` appear one clock later.

Top module: `nsat_interleave_top`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and `dst_o` is all zeros, and the clear takes effect without waiting for a clock edge.
- R2: `out_valid_o` is 1 in the cycle after a cycle with `in_valid_i` high, and 0 in the cycle after a cycle with `in_valid_i` low.
- R3: When `in_valid_i` is low, `dst_o` keeps its value on the next edge, whatever the other inputs are doing.
- R4: With `mode_i` = 0 (16-bit to 8-bit), the shift is 8 minus `imm_i[2:0]`, which gives a range of 1 to 8. `imm_i[3]` has no effect on the result.
- R5: With `mode_i` = 1 (32-bit to 16-bit), the shift is 16 minus `imm_i[3:0]`, which gives a range of 1 to 16.
- R6: Each result equals floor((x + 2^(shift-1)) / 2^shift), where x is the signed wide element. An exact half therefore rounds upward.
- R7: A result below zero becomes 0. In particular, every negative input element yields 0.
- R8: A result above 2^N-1 becomes 2^N-1 (all ones), where N is the narrow width.
- R9: Wide element e occupies source bits [e*2N +: 2N]. Its result from source i (0 for `src0_i`, 1 for `src1_i`) goes to destination bits [(2e+i)*N +: N].
- R10: The rounding addition does not wrap. The largest positive input at a shift of 1 saturates to all ones, and the most negative input gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands are presented this cycle |
| mode_i | input | 1 | Size class: 0 = 16 to 8 bit, 1 = 32 to 16 bit |
| imm_i | input | 4 | Raw immediate field; bit 3 is ignored in class 0 |
| src0_i | input | VL | First source vector of signed wide elements |
| src1_i | input | VL | Second source vector of signed wide elements |
| out_valid_o | output | 1 | Result is valid |
| dst_o | output | VL | Interleaved narrow unsigned results |

## Verification
A wrong shift decode or a missing rounding increment makes whole lanes drift by one or by a power of two. A lane wired to the wrong source or element moves a result to a neighbouring slot. Any of these shows on `dst_o` in the very next cycle after the vector is accepted, because only one register stage lies between the operands and the output. The sweep covers every 16-bit input value at all eight byte-class shifts, so an error in a single lane or a single shift value cannot stay hidden. Halfword-class ties, extremes and random values then cover the wider path, including the wrap that insufficient headroom would cause.

// File: rtl/nsat_pkg.sv
package nsat_pkg;
  typedef enum logic {
    CLS_B8  = 1'b0,
    CLS_H16 = 1'b1
  } nsat_cls_e;

  localparam int unsigned NW_B = 8;
  localparam int unsigned NW_H = 16;
  localparam int unsigned IMM_W = 4;
endpackage

// File: rtl/nsat_shift_decode.sv
module nsat_shift_decode #(
  parameter int unsigned NW    = 8,
  parameter int unsigned IMM_W = 4,
  localparam int unsigned SW   = $clog2(NW) + 1,
  localparam int unsigned FW   = $clog2(NW)
) (
  input  logic [IMM_W-1:0] imm_i,
  output logic [SW-1:0]    sh_o
);
  // Only the low log2(NW) bits of the immediate belong to this class.
  logic [FW-1:0] fld;
  assign fld  = imm_i[FW-1:0];
  assign sh_o = SW'(NW) - {1'b0, fld};
endmodule

// File: rtl/nsat_lane.sv
module nsat_lane #(
  parameter int unsigned NW = 8,
  localparam int unsigned WW = 2 * NW,
  localparam int unsigned SW = $clog2(NW) + 1
) (
  input  logic [WW-1:0] wide_i,
  input  logic [SW-1:0] sh_i,
  output logic [NW-1:0] nar_o
);
  // One guard bit so that the rounding increment cannot wrap.
  logic signed [WW:0] ext, rnd, sum, q;

  always_comb begin
    ext = signed'({wide_i[WW-1], wide_i});
    rnd = signed'((WW+1)'(1) << (sh_i - SW'(1)));
    sum = ext + rnd;
    q   = sum >>> sh_i;
    if (q[WW])
      nar_o = '0;
    else if (|q[WW-1:NW])
      nar_o = '1;
    else
      nar_o = q[NW-1:0];
  end
endmodule

// File: rtl/nsat_class_path.sv
module nsat_class_path #(
  parameter int unsigned NW = 8,
  parameter int unsigned VL = 128,
  localparam int unsigned WW = 2 * NW,
  localparam int unsigned NE = VL / WW,
  localparam int unsigned SW = $clog2(NW) + 1
) (
  input  logic [VL-1:0] src0_i,
  input  logic [VL-1:0] src1_i,
  input  logic [SW-1:0] sh_i,
  output logic [VL-1:0] dst_o
);
  logic [1:0][VL-1:0] src_pair;
  assign src_pair = {src1_i, src0_i};

  for (genvar e = 0; e < NE; e++) begin : g_elem
    for (genvar i = 0; i < 2; i++) begin : g_src
      nsat_lane #(.NW(NW)) i_lane (
        .wide_i (src_pair[i][e*WW +: WW]),
        .sh_i   (sh_i),
        .nar_o  (dst_o[(2*e+i)*NW +: NW])
      );
    end
  end
endmodule

// File: rtl/nsat_interleave_top.sv
module nsat_interleave_top #(
  parameter int unsigned VL = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          mode_i,
  input  logic [3:0]    imm_i,
  input  logic [VL-1:0] src0_i,
  input  logic [VL-1:0] src1_i,
  output logic          out_valid_o,
  output logic [VL-1:0] dst_o
);
  import nsat_pkg::*;

  localparam int unsigned SW_B = $clog2(NW_B) + 1;
  localparam int unsigned SW_H = $clog2(NW_H) + 1;

  nsat_cls_e     cls;
  logic [SW_B-1:0] sh_b;
  logic [SW_H-1:0] sh_h;
  logic [VL-1:0]   res_b, res_h, res_d;

  assign cls = nsat_cls_e'(mode_i);

  nsat_shift_decode #(.NW(NW_B), .IMM_W(IMM_W)) i_dec_b (.imm_i(imm_i), .sh_o(sh_b));
  nsat_shift_decode #(.NW(NW_H), .IMM_W(IMM_W)) i_dec_h (.imm_i(imm_i), .sh_o(sh_h));

  nsat_class_path #(.NW(NW_B), .VL(VL)) i_path_b (
    .src0_i (src0_i),
    .src1_i (src1_i),
    .sh_i   (sh_b),
    .dst_o  (res_b)
  );

  nsat_class_path #(.NW(NW_H), .VL(VL)) i_path_h (
    .src0_i (src0_i),
    .src1_i (src1_i),
    .sh_i   (sh_h),
    .dst_o  (res_h)
  );

  assign res_d = (cls == CLS_H16) ? res_h : res_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) dst_o <= res_d;
    end
  end
endmodule

// File: rtl/nsat_interleave_chk.sv
module nsat_interleave_chk #(
  parameter int unsigned VL = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          mode_i,
  input logic [3:0]    imm_i,
  input logic [VL-1:0] src0_i,
  input logic [VL-1:0] src1_i,
  input logic          out_valid_o,
  input logic [VL-1:0] dst_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R3
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dst_o));

  // R7
  neg_zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !mode_i && src0_i[15]) |=> (dst_o[7:0] == 8'h00));

  // R7
  neg_zero_h_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i && src1_i[31]) |=> (dst_o[31:16] == 16'h0000));

  // R8
  sat_ones_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !mode_i && imm_i[2:0] == 3'd7 && !src0_i[15] && (|src0_i[14:9]))
      |=> (dst_o[7:0] == 8'hFF));
endmodule

bind nsat_interleave_top nsat_interleave_chk #(.VL(VL)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .mode_i      (mode_i),
  .imm_i       (imm_i),
  .src0_i      (src0_i),
  .src1_i      (src1_i),
  .out_valid_o (out_valid_o),
  .dst_o       (dst_o)
);

// File: tb/test_nsat_interleave_top.sv
`timescale 1ns/1ps
module test_nsat_interleave_top;
  localparam int unsigned VL = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [3:0]    imm_i = '0;
  logic [VL-1:0] src0_i = '0;
  logic [VL-1:0] src1_i = '0;
  logic          out_valid_o;
  logic [VL-1:0] dst_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  nsat_interleave_top #(.VL(VL)) i_nsat_interleave_top (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .mode_i      (mode_i),
    .imm_i       (imm_i),
    .src0_i      (src0_i),
    .src1_i      (src1_i),
    .out_valid_o (out_valid_o),
    .dst_o       (dst_o)
  );

  function automatic logic [VL-1:0] model(logic m, logic [3:0] im,
                                          logic [VL-1:0] a, logic [VL-1:0] b);
    int nw = m ? 16 : 8;
    int sh = m ? 16 - int'(im) : 8 - int'(im[2:0]);
    int ne = VL / (2 * nw);
    longint mx = (longint'(1) << nw) - 1;
    logic [VL-1:0] r = '0;
    for (int e = 0; e < ne; e++) begin
      for (int i = 0; i < 2; i++) begin
        logic [VL-1:0] w = (i == 0) ? a : b;
        longint x, q;
        if (m) x = longint'($signed(w[e*32 +: 32]));
        else   x = longint'($signed(w[e*16 +: 16]));
        q = (x + (longint'(1) <<< (sh - 1))) >>> sh;
        if (q < 0)  q = 0;
        if (q > mx) q = mx;
        if (m) r[(2*e+i)*16 +: 16] = 16'(q);
        else   r[(2*e+i)*8 +: 8]   = 8'(q);
      end
    end
    return r;
  endfunction

  task automatic apply(input logic m, input logic [3:0] im,
                       input logic [VL-1:0] a, input logic [VL-1:0] b,
                       input string tag);
    logic [VL-1:0] exp;
    exp        = model(m, im, a, b);
    mode_i     = m;
    imm_i      = im;
    src0_i     = a;
    src1_i     = b;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    n_vec++;
    if (out_valid_o !== 1'b1 || dst_o !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d imm=%0d: valid=%b dst=%h expected valid=1 dst=%h",
               tag, m, im, out_valid_o, dst_o, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    logic [VL-1:0] held;
    held       = dst_o;
    in_valid_i = 1'b0;
    mode_i     = ~mode_i;
    imm_i      = ~imm_i;
    src0_i     = ~src0_i;
    src1_i     = {VL/32{$urandom()}};
    @(negedge clk_i);
    n_vec++;
    if (out_valid_o !== 1'b0 || dst_o !== held) begin
      n_bad++;
      $display("FAIL %s: valid=%b dst=%h expected valid=0 dst=%h",
               tag, out_valid_o, dst_o, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [VL-1:0] a, b;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (out_valid_o !== 1'b0 || dst_o !== '0) begin
      n_bad++;
      $display("FAIL R1: valid=%b dst=%h expected 0 0", out_valid_o, dst_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 R6 R7 R8 R9: every 16-bit value at every byte-class shift
    for (int im = 0; im < 8; im++) begin
      for (int k = 0; k < 4096; k++) begin
        for (int j = 0; j < 8; j++) begin
          a[j*16 +: 16] = 16'(k*16 + j);
          b[j*16 +: 16] = 16'(k*16 + 8 + j);
        end
        apply(1'b0, 4'(im), a, b, "R4 R6 R7 R8 R9 byte sweep");
      end
    end

    // R4: bit 3 of the immediate must not matter in byte class
    for (int k = 0; k < 512; k++) begin
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      apply(1'b0, 4'(8 + (k % 8)), a, b, "R4 imm bit3 ignored");
    end

    // R3: idle cycle keeps the previous result
    idle_check("R3 R2 hold with in_valid low");

    // R5 R6: halfword ties and small values at shift 1 and 16
    apply(1'b1, 4'd15, {32'd7, 32'd5, 32'd3, 32'd1},
                       {32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'd2, 32'd0}, "R5 R6 ties shift 1");
    apply(1'b1, 4'd0,  {32'h0001_8000, 32'h0000_7FFF, 32'h0000_8000, 32'h0001_0000},
                       {32'hFFFF_8000, 32'h7FFF_FFFF, 32'h0002_7FFF, 32'h0000_0000},
                       "R5 R6 ties shift 16");
    // R10 R8 R7 extremes
    apply(1'b1, 4'd15, {32'h7FFF_FFFF, 32'h8000_0000, 32'h0002_0000, 32'h0001_FFFF},
                       {32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_FFFE, 32'h0000_FFFF},
                       "R10 R8 R7 extremes shift 1");
    apply(1'b1, 4'd0,  {32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_8000, 32'h7FFF_7FFF},
                       {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001},
                       "R10 R6 extremes shift 16");
    apply(1'b0, 4'd7,  {8{16'h7FFF}}, {8{16'h8000}}, "R10 byte extremes shift 1");
    apply(1'b0, 4'd0,  {8{16'h7FFF}}, {8{16'h8000}}, "R10 byte extremes shift 8");

    // R5 R6 R7 R8 R9: random halfword vectors across all shifts
    for (int k = 0; k < 4000; k++) begin
      a = {$urandom(), $urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (k % 3 == 0) begin
        a = a >> (k % 17);
        b = b >> (k % 19);
      end
      apply(1'b1, 4'(k % 16), a, b, "R5 R6 R7 R8 R9 halfword random");
      if (k % 500 == 0) idle_check("R3 hold halfword");
    end

    // R1: asynchronous clear during operation
    apply(1'b1, 4'd15, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, "R8 before reset");
    in_valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    n_vec++;
    if (out_valid_o !== 1'b0 || dst_o !== '0) begin
      n_bad++;
      $display("FAIL R1 async clear: valid=%b dst=%h expected 0 0", out_valid_o, dst_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    apply(1'b0, 4'd3, {8{16'h0123}}, {8{16'hF00D}}, "R2 R9 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule